// File: doc/BRIEF.md
# Scanline Burst DMA Engine

This block moves a short run of bytes between two buses once per scanline. Each time the horizontal blanking input rises, it copies a burst of one to four bytes. Normally the copy runs from a work-memory bus into a bank of video control registers. It can also run the other way, reading control registers and storing the bytes into memory. The engine keeps a source pointer that walks forward across successive scanlines. The pointer is reloaded from a base address when the vertical blanking input rises, so every frame replays the same table.

While a burst runs, the engine raises a hold output. A general block-copy DMA engine sharing the buses must freeze while hold is high, keeping its own address and count, and carry on once hold drops. The blanking engine therefore always wins the buses.

The engine has no input for the display's forced-blank state, so bursts continue on every scanline whether or not the picture is shown. If blanking ends before a burst is complete, the remaining bytes are dropped and a sticky overrun flag is raised.

Top module: `scanline_burst_dma`

## Requirements
- R1: The burst length comes from the 2-bit field `cfg_len`: value L gives L+1 bytes, so 00 moves 1 byte and 11 moves 4 bytes. A complete burst issues exactly L+1 read strobes and L+1 write strobes.
- R2: A burst starts only at a clock edge that samples `hblank` high when it was sampled low at the edge before. The first read strobe appears in the cycle after that edge. For byte k, the read falls in burst cycle 2k and the write in cycle 2k+1. No further burst starts until `hblank` has fallen and risen again.
- R3: In any cycle at most one of `mem_rd`, `mem_wr`, `reg_rd` and `reg_wr` is high. `hold` is high exactly in the cycles where one of them is high. A block DMA that advances only while `hold` is low loses exactly the burst cycles.
- R4: With `cfg_dir` = 0, each byte is a `mem_rd` followed by a `reg_wr` that carries the byte read. With `cfg_dir` = 1, each byte is a `reg_rd` followed by a `mem_wr` that carries the register byte.
- R5: Byte k uses register address `cfg_dst` + k, wrapping within the register width. It uses memory address pointer + k. The pointer advances by one for every write cycle issued, and the advance carries over to the next scanline's burst.
- R6: A rising edge on `vblank` loads the pointer from `cfg_base`, so the next burst starts reading or writing memory at that base.
- R7: When `en` is low at the edge where a burst would start, no burst occurs. When `en` is low at any edge, `hold` and all strobes are low in the following cycle. The burst is dropped without setting `overrun`.
- R8: If `hblank` is sampled low at an edge while a burst still has cycles left, the remaining bytes are dropped and `overrun` goes high and stays high until reset. Bytes whose write cycle was issued still advance the pointer. A burst that completes leaves `overrun` unchanged.
- R9: Length, direction and destination are captured at the start edge. Changing `cfg_len`, `cfg_dir` or `cfg_dst` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable |
| hblank | input | 1 | Horizontal blanking level |
| vblank | input | 1 | Vertical blanking level; rising edge reloads pointer |
| cfg_base | input | AW | Frame base address for the memory pointer |
| cfg_dst | input | RW | First register address of each burst |
| cfg_len | input | 2 | Burst length code, bytes = value + 1 |
| cfg_dir | input | 1 | 0 = memory to registers, 1 = registers to memory |
| mem_addr | output | AW | Memory-side address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the read cycle |
| reg_addr | output | RW | Register-side address |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | DW | Register write data |
| reg_rdata | input | DW | Register read data, valid in the read cycle |
| hold | output | 1 | Pre-emption hold for the block DMA engine |
| overrun | output | 1 | Sticky flag: a burst was cut short by end of blanking |

## Verification
A burst whose rising `hblank` is sampled at edge E0 puts byte k's read in the cycle after edge E(2k) and its write in the cycle after E(2k+1). Both `hold` and the strobes drop in the cycle after the last write, or in the cycle after any edge that samples `hblank` or `en` low. The bench drives inputs and samples outputs at the falling edge, indexing each sample by the number of rising edges since the start edge. From the cut-off edges and the burst length it works out which cycles must carry which strobe, address and data, when `overrun` must be set, and how far the pointer must have moved, which the following burst then exposes. A model block DMA that counts only cycles without `hold` is compared against the elapsed cycles minus the expected burst cycles.

// File: rtl/sbd_pkg.sv
// Shared types for the scanline burst DMA engine.
// Assumes: nothing beyond IEEE 1800-2017.
package sbd_pkg;

    // Width of the burst length code (bytes = code + 1).
    localparam int LEN_W = 2;

    // Burst sequencer states: one read cycle then one write cycle per byte.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sbd_rise.sv
// Rising-edge detector for a level input sampled on the block clock.
// Assumes: the input is already synchronous to clk.
module sbd_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    // A rise is a high level that was low one edge earlier.
    always_comb begin
        rise = level & ~level_q;
    end

endmodule

// File: rtl/sbd_src_ptr.sv
// Memory-side pointer: loads a base on frame start, steps by one per byte.
// Assumes: reload and advance are single-cycle qualifiers; reload wins.
module sbd_src_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [AW-1:0] base,
    input  logic          advance,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] STEP = AW'(1);

    // Hold, reload or step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (reload) begin
            ptr <= base;
        end else if (advance) begin
            ptr <= ptr + STEP;
        end
    end

endmodule

// File: rtl/sbd_sequencer.sv
// Burst sequencer: starts a burst on a blanking rise, walks read/write
// cycle pairs, and abandons the burst when blanking ends or the enable drops.
// Assumes: hb_rise is the registered rising edge of hblank; config is
// captured at the start edge and ignored afterwards.
module sbd_sequencer
    import sbd_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hblank,
    input  logic             hb_rise,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_dir,
    input  logic [RW-1:0]    cfg_dst,
    output seq_state_e       state,
    output logic [LEN_W-1:0] byte_idx,
    output logic             dir_q,
    output logic [RW-1:0]    dst_q,
    output logic             byte_done,
    output logic             overrun
);

    localparam logic [LEN_W-1:0] IDX_STEP = LEN_W'(1);

    logic [LEN_W-1:0] len_q;
    logic             last_byte;

    // Current byte is the final one of the captured length.
    always_comb begin
        last_byte = (byte_idx == len_q);
        byte_done = (state == SEQ_WRITE);
    end

    // Burst state machine with abandon and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            byte_idx <= '0;
            len_q    <= '0;
            dir_q    <= 1'b0;
            dst_q    <= '0;
            overrun  <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (en && hb_rise) begin
                        state    <= SEQ_READ;
                        byte_idx <= '0;
                        len_q    <= cfg_len;
                        dir_q    <= cfg_dir;
                        dst_q    <= cfg_dst;
                    end
                end
                SEQ_READ: begin
                    if (!en) begin
                        state <= SEQ_IDLE;
                    end else if (!hblank) begin
                        state   <= SEQ_IDLE;
                        overrun <= 1'b1;
                    end else begin
                        state <= SEQ_WRITE;
                    end
                end
                SEQ_WRITE: begin
                    if (last_byte || !en) begin
                        state <= SEQ_IDLE;
                    end else if (!hblank) begin
                        state   <= SEQ_IDLE;
                        overrun <= 1'b1;
                    end else begin
                        state    <= SEQ_READ;
                        byte_idx <= byte_idx + IDX_STEP;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sbd_bus_steer.sv
// Bus steering: maps sequencer cycles onto the memory or register strobes
// according to direction, forms addresses, and holds the byte in flight.
// Assumes: read data is valid combinationally in the read cycle.
module sbd_bus_steer
    import sbd_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state,
    input  logic             dir_q,
    input  logic [RW-1:0]    dst_q,
    input  logic [LEN_W-1:0] byte_idx,
    input  logic [AW-1:0]    ptr,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    reg_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    output logic [RW-1:0]    reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [DW-1:0]    reg_wdata,
    output logic             hold
);

    logic          in_read;
    logic          in_write;
    logic [DW-1:0] data_q;

    // Decode the cycle type and steer strobes by direction.
    always_comb begin
        in_read   = (state == SEQ_READ);
        in_write  = (state == SEQ_WRITE);
        mem_rd    = in_read  & ~dir_q;
        reg_wr    = in_write & ~dir_q;
        reg_rd    = in_read  &  dir_q;
        mem_wr    = in_write &  dir_q;
        hold      = in_read | in_write;
        mem_addr  = ptr;
        reg_addr  = dst_q + RW'(byte_idx);
        mem_wdata = data_q;
        reg_wdata = data_q;
    end

    // Capture the byte fetched in a read cycle for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (in_read) begin
            data_q <= dir_q ? reg_rdata : mem_rdata;
        end
    end

endmodule

// File: rtl/scanline_burst_dma.sv
// Scanline burst DMA engine top: one 1..4 byte burst per horizontal blank,
// pre-empting a block DMA through hold, pointer reloaded per frame.
// Assumes: hblank and vblank are synchronous levels; the block DMA engine
// freezes whenever hold is high.
module scanline_burst_dma
    import sbd_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hblank,
    input  logic             vblank,
    input  logic [AW-1:0]    cfg_base,
    input  logic [RW-1:0]    cfg_dst,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_dir,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [RW-1:0]    reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata,
    output logic             hold,
    output logic             overrun
);

    logic             hb_rise;
    logic             vb_rise;
    seq_state_e       state;
    logic [LEN_W-1:0] byte_idx;
    logic             dir_q;
    logic [RW-1:0]    dst_q;
    logic             byte_done;
    logic [AW-1:0]    ptr;

    sbd_rise u_hb_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (hblank),
        .rise  (hb_rise)
    );

    sbd_rise u_vb_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (vblank),
        .rise  (vb_rise)
    );

    sbd_sequencer #(.RW(RW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hblank    (hblank),
        .hb_rise   (hb_rise),
        .cfg_len   (cfg_len),
        .cfg_dir   (cfg_dir),
        .cfg_dst   (cfg_dst),
        .state     (state),
        .byte_idx  (byte_idx),
        .dir_q     (dir_q),
        .dst_q     (dst_q),
        .byte_done (byte_done),
        .overrun   (overrun)
    );

    sbd_src_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (vb_rise),
        .base    (cfg_base),
        .advance (byte_done),
        .ptr     (ptr)
    );

    sbd_bus_steer #(.AW(AW), .RW(RW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .dir_q     (dir_q),
        .dst_q     (dst_q),
        .byte_idx  (byte_idx),
        .ptr       (ptr),
        .mem_rdata (mem_rdata),
        .reg_rdata (reg_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .hold      (hold)
    );

endmodule

// File: rtl/sbd_checker.sv
// Property checker for the scanline burst DMA engine, bound to the top.
// Assumes: reset is held for at least two clock edges before release.
module sbd_checker #(
    parameter int AW = 16,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          hblank,
    input logic          vblank,
    input logic          hold,
    input logic          overrun,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [AW-1:0] mem_addr,
    input logic [RW-1:0] reg_addr
);

    // R3: never more than one bus strobe in a cycle.
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, reg_rd, reg_wr}) <= 1);

    // R3: hold tracks bus activity exactly.
    a_r3_hold_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hold == (mem_rd | mem_wr | reg_rd | reg_wr));

    // R2: no burst begins while blanking is low.
    a_r2_no_start_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !hblank) |=> !hold);

    // R7: a low enable clears hold in the next cycle.
    a_r7_disable_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hold);

    // R8: overrun is sticky.
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R4: a memory read is followed by a register write while allowed.
    a_r4_mem_then_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && en && hblank) |=> reg_wr);

    // R4: a register read is followed by a memory write while allowed.
    a_r4_reg_then_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && en && hblank) |=> mem_wr);

    // R5: register address steps by one between consecutive bytes.
    a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && $past(reg_wr, 2)) |->
            (reg_addr == RW'($past(reg_addr, 2) + 1'b1)));

    // R5: memory address steps by one between consecutive reads.
    a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd, 2) && !vblank && !$past(vblank) && !$past(vblank, 2)) |->
            (mem_addr == AW'($past(mem_addr, 2) + 1'b1)));

endmodule

bind scanline_burst_dma sbd_checker #(.AW(AW), .RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .hblank   (hblank),
    .vblank   (vblank),
    .hold     (hold),
    .overrun  (overrun),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .mem_addr (mem_addr),
    .reg_addr (reg_addr)
);

// File: tb/scanline_burst_dma_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps length, direction, destination, blanking cut-off and enable
// cut-off, with every expected cycle computed arithmetically.
module scanline_burst_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_dst = '0;
    logic [1:0]  cfg_len = '0;
    logic        cfg_dir = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, reg_rd, reg_wr, hold, overrun;
    logic [7:0]  mem_wdata, mem_rdata, reg_addr, reg_wdata, reg_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_ptr = '0;
    logic        exp_ovr = 1'b0;
    int cyc = 0;
    int gaddr = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fmem(input logic [15:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd7;
        return p ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] freg(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    assign mem_rdata = fmem(mem_addr);
    assign reg_rdata = freg(reg_addr);

    // Model block DMA: advances only while not held.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && !hold) gaddr <= gaddr + 1;
    end

    scanline_burst_dma dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .hblank(hblank), .vblank(vblank),
        .cfg_base(cfg_base), .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_dir(cfg_dir),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold(hold), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] pack(input logic mr, input logic mw, input logic rr,
                                         input logic rw, input logic h, input logic [15:0] ma,
                                         input logic [7:0] ra, input logic [7:0] d);
        return {27'd0, mr, mw, rr, rw, h, (mr | mw) ? ma : 16'h0,
                (rr | rw) ? ra : 8'h0, mw ? d : (rw ? d : 8'h0)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        hblank = 1'b0;
        vblank = 1'b0;
        en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ptr = '0;
        exp_ovr = 1'b0;
        @(negedge clk);
        chk("R3 reset strobes/hold", {59'd0, mem_rd, mem_wr, reg_rd, reg_wr, hold}, 64'd0);
        chk("R8 reset overrun", {63'd0, overrun}, 64'd0);
    endtask

    task automatic frame(input logic [15:0] base);
        @(negedge clk);
        cfg_base = base;
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
        exp_ptr = base;
    endtask

    // One scanline: blanking held for H edges, enable dropped at edge M.
    task automatic run_line(input string tag, input logic [1:0] len, input logic dir,
                            input logic [7:0] dst, input int H, input int M);
        int n, nexist, lim, c0, g0;
        logic [63:0] e;
        n = int'(len) + 1;
        nexist = 2 * n;
        if (H < nexist) nexist = H;
        if (M < nexist) nexist = M;
        lim = ((H > 2 * n) ? H : 2 * n) + 2;
        @(negedge clk);
        cfg_len = len;
        cfg_dir = dir;
        cfg_dst = dst;
        hblank = 1'b1;
        if (M == 0) en = 1'b0;
        c0 = cyc;
        g0 = gaddr;
        for (int j = 0; j < lim; j++) begin
            @(negedge clk);
            if (j < nexist) begin
                logic [15:0] ma;
                logic [7:0]  ra;
                ma = exp_ptr + 16'(j / 2);
                ra = dst + 8'(j / 2);
                if (j % 2 == 0)
                    e = pack(!dir, 1'b0, dir, 1'b0, 1'b1, ma, ra, 8'h0);
                else
                    e = pack(1'b0, dir, 1'b0, !dir, 1'b1, ma, ra, dir ? freg(ra) : fmem(ma));
            end else begin
                e = pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h0);
            end
            chk(tag, pack(mem_rd, mem_wr, reg_rd, reg_wr, hold, mem_addr, reg_addr,
                          mem_wr ? mem_wdata : reg_wdata), e);
            if (j == 0) begin
                cfg_dst = ~dst;
                cfg_len = ~len;
                cfg_dir = ~dir;
            end
            if (j == H - 1) hblank = 1'b0;
            if (j == M - 1) en = 1'b0;
        end
        en = 1'b1;
        exp_ptr = exp_ptr + 16'(nexist / 2);
        if ((H < 2 * n) && (H < M)) exp_ovr = 1'b1;
        chk({tag, " R8 overrun"}, {63'd0, overrun}, {63'd0, exp_ovr});
        chk({tag, " R3 block DMA progress"}, 64'(gaddr - g0), 64'((cyc - c0) - nexist));
    endtask

    initial begin
        do_reset();
        frame(16'h0100);
        // R1 R2 R4 R5 R9: every length, both directions, two destinations.
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 4; l++)
                for (int k = 0; k < 2; k++)
                    run_line("R1 R2 R4 R5 R9 sweep", 2'(l), d[0], k ? 8'hFE : 8'h10, 20, 99);
        // R6: frame reload to a base near the top of the address space.
        frame(16'hFFFE);
        run_line("R6 reload", 2'd3, 1'b0, 8'h40, 12, 99);
        frame(16'h0200);
        run_line("R6 reload dir1", 2'd2, 1'b1, 8'h20, 12, 99);
        // R7: enable low at start, then dropped at each burst edge.
        for (int m = 0; m < 8; m++)
            run_line("R7 enable cut", 2'd3, m[0], 8'h30, 20, m);
        // R8: blanking cut at each burst edge.
        for (int h = 1; h < 8; h++)
            run_line("R8 blank cut", 2'd3, h[0], 8'h50, h, 99);
        do_reset();
        frame(16'h0300);
        run_line("R8 full burst after reset", 2'd1, 1'b0, 8'h60, 10, 99);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        nfail++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule